// File: doc/BRIEF.md
# Self-Purging Majority Voter

This block combines the single-bit outputs of N redundant modules into one voted bit and removes modules that disagree. Every module starts in the active set. On each valid strobe the block counts the ones among the active modules only, so a module weighs 1 while active and 0 once removed. It then compares twice that count against the number of active modules. This add-and-compare form scales to five, seven or more inputs, where a gate-level majority network would grow far too large.

When the vote is decisive, the voted bit is registered. Every active module whose bit differs from it leaves the active set at the same clock edge and stays out until reset. An exact tie among the active modules holds the previous voted bit and removes no module. The block reports the active mask, the number of active modules, and a failure flag that rises when fewer than two modules remain.

Top module: `purge_voter`

## Requirements
- R1: During and after reset, before any valid strobe, the active mask is all ones, the active count equals N, the voted bit is 0 and the failure flag is low.
- R2: At a clock edge where `in_valid` is high, the voted bit becomes 1 if twice the number of active modules presenting 1 exceeds the active count, and 0 if it is less. The new value is visible after that edge.
- R3: At a clock edge with a decisive valid vote, every active module whose input bit differs from the new voted bit is cleared from the active mask. Active modules that agree with the vote stay in the mask.
- R4: When twice the number of active ones equals the active count exactly, a valid strobe leaves the voted bit and the active mask unchanged.
- R5: A cleared module stays cleared until reset, and its input bit has no effect on the vote.
- R6: With `in_valid` low, the voted bit and the active mask keep their values whatever the module inputs do.
- R7: `active_cnt` always equals the number of ones in `active_mask`.
- R8: `failed` is high exactly when fewer than two modules are active. Because only a strict minority is removed, for N of 2 or more the count never falls below two and `failed` stays low.
- R9: N is a parameter, and the same behaviour holds for N = 5 and N = 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: vote on this cycle's inputs |
| mod_bits | input | N | One output bit per redundant module |
| vote_out | output | 1 | Registered voted bit |
| active_mask | output | N | Bit i high while module i is active |
| active_cnt | output | $clog2(N+1) | Number of active modules |
| failed | output | 1 | High when fewer than two modules are active |

## Verification
The assertions check on every cycle that the mask never regains a bit before reset, that idle cycles change nothing, that an exact tie holds both vote and mask, that only modules disagreeing with the new vote are removed, and that the active count stays at two or more. Whether the voted bit has the correct value, and how purging unfolds over a sequence, depend on the history. Only the bench scenarios show these, by comparing against a reference model. The scenarios include a purged module outvoting the survivors, repeated ties, and reset in the middle of a run, for both five and seven modules.

// File: rtl/purge_voter.sv
module purge_voter #(
  parameter int N = 5,
  localparam int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [N-1:0]  mod_bits,
  output logic          vote_out,
  output logic [N-1:0]  active_mask,
  output logic [CW-1:0] active_cnt,
  output logic          failed
);

  logic [CW-1:0] ones_c, cnt_c;
  logic [CW:0]   twice_ones;
  logic          tie, maj;

  always_comb begin
    ones_c = '0;
    cnt_c  = '0;
    for (int i = 0; i < N; i++) begin
      ones_c = ones_c + CW'(mod_bits[i] & active_mask[i]);
      cnt_c  = cnt_c + CW'(active_mask[i]);
    end
  end

  assign twice_ones = {ones_c, 1'b0};
  assign tie = (twice_ones == {1'b0, cnt_c});
  assign maj = (twice_ones > {1'b0, cnt_c});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_mask <= '1;
      vote_out    <= 1'b0;
    end else if (in_valid && !tie) begin
      vote_out    <= maj;
      active_mask <= active_mask & ~(mod_bits ^ {N{maj}});
    end
  end

  assign active_cnt = cnt_c;
  assign failed     = (cnt_c < CW'(2));

endmodule

module purge_voter_chk #(
  parameter int N = 5,
  localparam int CW = $clog2(N + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [N-1:0]  mod_bits,
  input logic          vote_out,
  input logic [N-1:0]  active_mask,
  input logic [CW-1:0] active_cnt,
  input logic          failed
);

  // R5
  mask_no_regrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((active_mask & ~$past(active_mask)) == '0));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(active_mask) && $stable(vote_out)));

  // R4
  tie_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ($countones(mod_bits & active_mask) * 2 == $countones(active_mask)))
      |=> ($stable(active_mask) && $stable(vote_out)));

  // R3
  purge_only_dissent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((($past(active_mask) & ~active_mask) & ~($past(mod_bits) ^ {N{vote_out}})) == '0));

  // R8
  floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (N >= 2) |-> (!failed && ($countones(active_mask) >= 2)));

endmodule

bind purge_voter purge_voter_chk #(.N(N)) u_chk (.*);

// File: tb/purge_voter_bench.sv
module purge_voter_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic v5 = 1'b0, v7 = 1'b0;
  logic [4:0] b5 = '0;
  logic [6:0] b7 = '0;
  logic o5, o7, f5, f7;
  logic [4:0] m5;
  logic [6:0] m7;
  logic [2:0] c5, c7;

  int tests = 0, fails = 0;
  logic       ev5, ev7;
  logic [6:0] em5, em7;

  always #(CLK_PERIOD / 2) clk = ~clk;

  purge_voter #(.N(5)) u_purge_voter (
    .clk(clk), .rst_n(rst_n), .in_valid(v5), .mod_bits(b5),
    .vote_out(o5), .active_mask(m5), .active_cnt(c5), .failed(f5));

  purge_voter #(.N(7)) u_purge_voter_n7 (
    .clk(clk), .rst_n(rst_n), .in_valid(v7), .mod_bits(b7),
    .vote_out(o7), .active_mask(m7), .active_cnt(c7), .failed(f7));

  function automatic int popc(logic [6:0] x);
    int n = 0;
    for (int i = 0; i < 7; i++) n += int'(x[i]);
    return n;
  endfunction

  task automatic model(input logic [6:0] b, inout logic [6:0] m, inout logic v);
    int ones = popc(b & m);
    int cnt  = popc(m);
    if (2 * ones != cnt) begin
      v = (2 * ones > cnt);
      m = m & ~(b ^ {7{v}});
    end
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "n5 vote", int'(o5), int'(ev5));
    chk(req, "n5 mask", int'(m5), int'(em5[4:0]));
    chk("R7", "n5 count", int'(c5), popc(em5));
    chk("R8", "n5 failed", int'(f5), int'(popc(em5) < 2));
    chk(req, "n7 vote", int'(o7), int'(ev7));
    chk(req, "n7 mask", int'(m7), int'(em7));
    chk("R7", "n7 count", int'(c7), popc(em7));
    chk("R8", "n7 failed", int'(f7), int'(popc(em7) < 2));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; v5 = 1'b0; v7 = 1'b0;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    ev5 = 1'b0; ev7 = 1'b0; em5 = 7'b0011111; em7 = 7'h7f;
    check_all("R1");
  endtask

  task automatic step(input string req, input logic val, input logic [4:0] x5, input logic [6:0] x7);
    b5 = x5; b7 = x7; v5 = val; v7 = val;
    @(posedge clk);
    if (val) begin
      model({2'b00, x5}, em5, ev5);
      model(x7, em7, ev7);
    end
    @(negedge clk);
    v5 = 1'b0; v7 = 1'b0;
    check_all(req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    @(negedge clk);
    do_reset();
    // R2 unanimous ones
    step("R2", 1'b1, 5'b11111, 7'h7f);
    // R3 minority removed: N5 drops 3,4; N7 drops 4..6
    step("R3", 1'b1, 5'b00111, 7'b0001111);
    // R5 purged modules high, survivors mostly low; R4 tie on N7 (2 of 4)
    step("R5", 1'b1, 5'b11001, 7'b0000011);
    // R4 tie on N5 (1 of 2), again tie on N7
    step("R4", 1'b1, 5'b00010, 7'b1110101);
    // R6 inputs toggle without strobe
    step("R6", 1'b0, 5'b11111, 7'h00);
    step("R6", 1'b0, 5'b00000, 7'h7f);
    // R1 reset restores full set
    do_reset();
    for (int k = 0; k < 600; k++) begin
      logic [4:0] r5;
      logic [6:0] r7;
      logic vv;
      if (k % 50 == 49) do_reset();
      r5 = {5{ev5}} ^ (5'($urandom) & 5'($urandom) & 5'($urandom));
      r7 = {7{ev7}} ^ (7'($urandom) & 7'($urandom) & 7'($urandom));
      if ($urandom_range(0, 9) == 0) begin r5 = 5'($urandom); r7 = 7'($urandom); end
      vv = ($urandom_range(0, 3) != 0);
      step(vv ? "R9" : "R6", vv, r5, r7);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule